// File: doc/BRIEF.md
# Edge-Sensed Interrupt Arbiter with Wake-Up

This block gathers interrupt requests from six external pins and six internal request lines. It turns them into a single prioritised request for the processor. Each external pin is brought into the clock domain through a two-stage synchroniser. An edge detector then fires on the falling or the rising transition, as chosen by a per-pin select bit. A detected edge sets a sticky pending bit, and software clears that bit by writing a one. Internal lines are level requests: their pending status follows the input directly.

Every source carries a three-bit priority level, and level 0 turns the source off. The arbiter reports the highest level among the pending sources together with the index of the winning source. When sources share a level, the fixed source index decides the winner.

A wake-up output serves the two low-power modes. Any enabled pending source wakes the core in the light sleep mode. In the deep stop mode, only the external pins can do so. A small word-addressed register port sets the edge selects, the wake mask and the levels, and reads back pending and raw pin state.

Top module: `intc_arb`

## Requirements
- R1: After reset, the edge-select, wake-enable, level and pending registers all read zero, and irq_valid_o and wake_o are low.
- R2: When edge-select bit i is 0, a high-to-low transition on ext_pin_i[i] sets pending bit i on the third rising clock edge after the pin is sampled low. A low-to-high transition on that pin sets nothing.
- R3: When edge-select bit i is 1, a low-to-high transition sets pending bit i with the same latency. A high-to-low transition on that pin sets nothing.
- R4: The pending register is at word offset 2. Bit i (0..5) is external pin i, and bit 6+j is int_req_i[j]. Writing 1 to an external bit clears it, and writing 0 leaves it unchanged. Internal bits always equal int_req_i, and writes to them have no effect.
- R5: A pending source whose level is 0 never wins. When no pending source has a non-zero level, irq_valid_o is low.
- R6: irq_level_o is the highest level among pending sources. Among sources at that level, irq_src_o is the lowest index, where index i<6 is external pin i and index 6+j is internal line j. Level registers for source k are at word offset 16+k.
- R7: When sleep_mode_i is high and stop_mode_i is low, wake_o is high exactly when some source is both pending and enabled in the wake mask (word offset 1, same bit order as pending).
- R8: When stop_mode_i is high, wake_o is high exactly when some external source (bits 0..5) is both pending and wake-enabled. Internal sources are ignored.
- R9: With both mode inputs low, wake_o is low.
- R10: The pin status register at word offset 3 returns the inverted synchronised pins: 1 for a low pin and 0 for a high pin. The upper bits read zero.
- R11: The edge-select register at word offset 0 keeps only bits 0..5, and its upper bits read zero after any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin_i | input | 6 | Asynchronous external interrupt pins |
| int_req_i | input | 6 | Internal level interrupt requests |
| sleep_mode_i | input | 1 | Light low-power mode active |
| stop_mode_i | input | 1 | Deep low-power mode active |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| irq_valid_o | output | 1 | A pending source with non-zero level exists |
| irq_level_o | output | 3 | Level of the winning source |
| irq_src_o | output | 4 | Index of the winning source |
| wake_o | output | 1 | Wake-up request |

## Verification
A corrupted pending bit shows up in the same cycle on irq_src_o, on irq_level_o and on the pending read-back. A bench that compares every cycle therefore catches it within one clock of the fault. A synchroniser or edge-detector fault moves the set of a pending bit away from the third edge after the pin is sampled, or lets the wrong polarity set it. Both are visible cycle-exactly against a model that delays the pin history. A wrong wake mask or a wrong mode filter shows on wake_o as soon as a pending enabled source exists in the mode that is affected.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int REG_TSEL = 0;
  localparam int REG_WAKE = 1;
  localparam int REG_PEND = 2;
  localparam int REG_PIN  = 3;
  localparam int REG_LVL0 = 16;

  // select 0: falling edge, select 1: rising edge
  function automatic logic edge_fire(input logic sel, input logic prev, input logic cur);
    return sel ? (cur & ~prev) : (~cur & prev);
  endfunction

  // next sticky state: set wins over a simultaneous clear
  function automatic logic sticky_next(input logic q, input logic set, input logic clr);
    return set | (q & ~clr);
  endfunction
endpackage

// File: rtl/intc_edge_sense.sv
module intc_edge_sense import intc_pkg::*; #(
  parameter int N_PIN = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_PIN-1:0] pin_i,
  input  logic [N_PIN-1:0] tsel_i,
  output logic [N_PIN-1:0] pin_sync_o,
  output logic [N_PIN-1:0] edge_o
);
  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= pin_i[g];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign pin_sync_o[g] = s2_q;
    assign edge_o[g]     = edge_fire(tsel_i[g], prev_q, s2_q);
  end
endmodule

// File: rtl/intc_level_arb.sv
module intc_level_arb #(
  parameter int N_SRC = 12,
  parameter int LVL_W = 3,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat_i,
  output logic                   valid_o,
  output logic [LVL_W-1:0]       level_o,
  output logic [SRC_W-1:0]       src_o
);
  always_comb begin
    logic [LVL_W-1:0] best;
    logic [SRC_W-1:0] idx;
    best = '0;
    idx  = '0;
    // scan from the top so that ">=" lets the lower index win ties
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i] && lvl_flat_i[i*LVL_W +: LVL_W] != '0 &&
          lvl_flat_i[i*LVL_W +: LVL_W] >= best) begin
        best = lvl_flat_i[i*LVL_W +: LVL_W];
        idx  = SRC_W'(i);
      end
    end
    level_o = best;
    src_o   = idx;
    valid_o = (best != '0);
  end
endmodule

// File: rtl/intc_wake_gen.sv
module intc_wake_gen #(
  parameter int N_EXT = 6,
  parameter int N_SRC = 12
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] wen_i,
  input  logic             sleep_i,
  input  logic             stop_i,
  output logic             wake_o
);
  localparam logic [N_SRC-1:0] EXT_MASK = N_SRC'((1 << N_EXT) - 1);
  logic [N_SRC-1:0] armed;
  assign armed = pend_i & wen_i;
  always_comb begin
    if (stop_i)       wake_o = |(armed & EXT_MASK);
    else if (sleep_i) wake_o = |armed;
    else              wake_o = 1'b0;
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb import intc_pkg::*; #(
  parameter int N_EXT  = 6,
  parameter int N_INT  = 6,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  localparam int N_SRC = N_EXT + N_INT,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic [N_INT-1:0]  int_req_i,
  input  logic              sleep_mode_i,
  input  logic              stop_mode_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_valid_o,
  output logic [LVL_W-1:0]  irq_level_o,
  output logic [SRC_W-1:0]  irq_src_o,
  output logic              wake_o
);
  logic [N_EXT-1:0]       tsel_q, pend_ext_q, pin_sync, edge_hit, pend_clr;
  logic [N_SRC-1:0]       wen_q, pend_all;
  logic [N_SRC*LVL_W-1:0] lvl_flat;
  logic                   wr_tsel, wr_wake, wr_pend;

  assign wr_tsel  = reg_wr_i && reg_addr_i == ADDR_W'(REG_TSEL);
  assign wr_wake  = reg_wr_i && reg_addr_i == ADDR_W'(REG_WAKE);
  assign wr_pend  = reg_wr_i && reg_addr_i == ADDR_W'(REG_PEND);
  assign pend_clr = wr_pend ? reg_wdata_i[N_EXT-1:0] : '0;
  assign pend_all = {int_req_i, pend_ext_q};

  intc_edge_sense #(.N_PIN(N_EXT)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i), .tsel_i(tsel_q),
    .pin_sync_o(pin_sync), .edge_o(edge_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsel_q     <= '0;
      wen_q      <= '0;
      pend_ext_q <= '0;
    end else begin
      if (wr_tsel) tsel_q <= reg_wdata_i[N_EXT-1:0];
      if (wr_wake) wen_q  <= reg_wdata_i[N_SRC-1:0];
      for (int i = 0; i < N_EXT; i++)
        pend_ext_q[i] <= sticky_next(pend_ext_q[i], edge_hit[i], pend_clr[i]);
    end
  end

  for (genvar k = 0; k < N_SRC; k++) begin : g_lvl
    logic [LVL_W-1:0] lvl_q;
    logic             wr_this;
    assign wr_this = reg_wr_i && reg_addr_i == ADDR_W'(REG_LVL0 + k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lvl_q <= '0;
      else if (wr_this) lvl_q <= reg_wdata_i[LVL_W-1:0];
    end
    assign lvl_flat[k*LVL_W +: LVL_W] = lvl_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(REG_TSEL))      reg_rdata_o[N_EXT-1:0] = tsel_q;
    else if (reg_addr_i == ADDR_W'(REG_WAKE)) reg_rdata_o[N_SRC-1:0] = wen_q;
    else if (reg_addr_i == ADDR_W'(REG_PEND)) reg_rdata_o[N_SRC-1:0] = pend_all;
    else if (reg_addr_i == ADDR_W'(REG_PIN))  reg_rdata_o[N_EXT-1:0] = ~pin_sync;
    else begin
      for (int k = 0; k < N_SRC; k++)
        if (reg_addr_i == ADDR_W'(REG_LVL0 + k))
          reg_rdata_o[LVL_W-1:0] = lvl_flat[k*LVL_W +: LVL_W];
    end
  end

  intc_level_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .req_i(pend_all), .lvl_flat_i(lvl_flat),
    .valid_o(irq_valid_o), .level_o(irq_level_o), .src_o(irq_src_o)
  );

  intc_wake_gen #(.N_EXT(N_EXT), .N_SRC(N_SRC)) u_wake (
    .pend_i(pend_all), .wen_i(wen_q), .sleep_i(sleep_mode_i),
    .stop_i(stop_mode_i), .wake_o(wake_o)
  );
endmodule

// File: rtl/intc_arb_chk.sv
module intc_arb_chk #(
  parameter int N_EXT  = 6,
  parameter int N_SRC  = 12,
  parameter int SRC_W  = 4,
  parameter int LVL_W  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_EXT-1:0]  edge_hit,
  input logic [N_EXT-1:0]  pend_ext_q,
  input logic [N_SRC-1:0]  pend_all,
  input logic [N_SRC-1:0]  wen_q,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              sleep_mode_i,
  input logic              stop_mode_i,
  input logic              irq_valid_o,
  input logic [LVL_W-1:0]  irq_level_o,
  input logic [SRC_W-1:0]  irq_src_o,
  input logic              wake_o
);
  logic [N_EXT-1:0] ext_armed;
  assign ext_armed = pend_all[N_EXT-1:0] & wen_q[N_EXT-1:0];

  for (genvar g = 0; g < N_EXT; g++) begin : g_bit
    AST_PEND_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_ext_q[g]) |-> $past(edge_hit[g])); // R2
    AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_addr_i == ADDR_W'(2) && reg_wdata_i[g] && !edge_hit[g])
      |=> !pend_ext_q[g]); // R4
  end

  AST_WIN_IS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_src_o < SRC_W'(N_SRC)) && pend_all[irq_src_o] && irq_level_o != '0); // R5
  AST_NONE_PENDING_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all == '0) |-> !irq_valid_o); // R5
  AST_STOP_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode_i && ext_armed == '0) |-> !wake_o); // R8
  AST_NO_MODE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_mode_i && !stop_mode_i) |-> !wake_o); // R9
  AST_SLEEP_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (pend_all & wen_q) != '0); // R7
endmodule

bind intc_arb intc_arb_chk #(
  .N_EXT(N_EXT), .N_SRC(N_SRC), .SRC_W(SRC_W), .LVL_W(LVL_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit), .pend_ext_q(pend_ext_q),
  .pend_all(pend_all), .wen_q(wen_q), .reg_wr_i(reg_wr_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .sleep_mode_i(sleep_mode_i), .stop_mode_i(stop_mode_i),
  .irq_valid_o(irq_valid_o), .irq_level_o(irq_level_o),
  .irq_src_o(irq_src_o), .wake_o(wake_o)
);

// File: tb/tb_intc_arb.sv
`timescale 1ns/1ps
module tb_intc_arb;
  localparam int NE = 6, NI = 6, NS = 12;

  logic        clk = 0, rst_n = 0;
  logic [5:0]  pins = 6'h3F, ireq = '0;
  logic        sleep_m = 0, stop_m = 0, wr = 0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        valid, wake;
  logic [2:0]  level;
  logic [3:0]  src;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intc_arb dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(pins), .int_req_i(ireq),
    .sleep_mode_i(sleep_m), .stop_mode_i(stop_m), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_valid_o(valid), .irq_level_o(level), .irq_src_o(src), .wake_o(wake)
  );

  // behavioural reference model
  logic [5:0] hist[$];
  int m_tsel, m_wen, m_pend;
  int m_lvl[NS];

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {6'h3F, 6'h3F, 6'h3F};
      m_tsel = 0; m_wen = 0; m_pend = 0;
      foreach (m_lvl[k]) m_lvl[k] = 0;
    end else begin
      int setv, clrv;
      setv = 0;
      for (int i = 0; i < NE; i++) begin
        bit cur, prv;
        cur = hist[1][i]; prv = hist[2][i];
        if (((m_tsel >> i) & 1) ? (cur && !prv) : (!cur && prv)) setv |= (1 << i);
      end
      clrv = (wr && addr == 2) ? int'(wdata[5:0]) : 0;
      m_pend = setv | (m_pend & ~clrv);
      if (wr && addr == 0) m_tsel = int'(wdata[5:0]);
      if (wr && addr == 1) m_wen = int'(wdata[11:0]);
      if (wr && addr >= 16 && addr < 16 + NS) m_lvl[addr - 16] = int'(wdata[2:0]);
      hist.push_front(pins);
      void'(hist.pop_back());
    end
  end

  function automatic int all_pend();
    return m_pend | (int'(ireq) << NE);
  endfunction

  task automatic exp_win(output int lv, output int ix);
    lv = 0; ix = 0;
    for (int l = 7; l >= 1 && lv == 0; l--)
      for (int i = 0; i < NS; i++)
        if (lv == 0 && ((all_pend() >> i) & 1) && m_lvl[i] == l) begin lv = l; ix = i; end
  endtask

  function automatic bit exp_wake();
    int armed;
    armed = all_pend() & m_wen;
    if (stop_m) return (armed & 6'h3F) != 0;
    if (sleep_m) return armed != 0;
    return 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int lv, ix;
      exp_win(lv, ix);
      chk("R5 R6 valid", int'(valid), int'(lv != 0));
      chk("R6 level", int'(level), lv);
      if (lv != 0) chk("R6 source", int'(src), ix);
      chk("R7 R8 R9 wake", int'(wake), int'(exp_wake()));
    end
  end

  task automatic wreg(input int a, input int d);
    @(negedge clk); wr = 1; addr = 5'(a); wdata = 32'(d);
    @(negedge clk); wr = 0;
  endtask

  task automatic rreg(input int a, input int exp, input string tag);
    addr = 5'(a); #0.5;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset state
    rreg(0, 0, "R1 tsel"); rreg(1, 0, "R1 wake en"); rreg(2, 0, "R1 pending");
    rreg(16, 0, "R1 level0"); chk("R1 valid", int'(valid), 0); chk("R1 wake", int'(wake), 0);

    // R2 falling edge default
    wreg(16, 3);
    pins[0] = 0; cyc(4);
    rreg(2, 1, "R2 falling sets"); chk("R6 single src", int'(src), 0); chk("R6 single lvl", int'(level), 3);
    wreg(2, 1); rreg(2, 0, "R4 write one clears");
    pins[0] = 1; cyc(4); rreg(2, 0, "R2 rising ignored");

    // R3 rising edge select
    wreg(0, 2);
    pins[1] = 0; cyc(4); rreg(2, 0, "R3 falling ignored");
    pins[1] = 1; cyc(4); rreg(2, 2, "R3 rising sets");
    rreg(0, 2, "R11 tsel readback");
    wreg(0, 32'hFFFF_FFFF); rreg(0, 32'h3F, "R11 upper bits zero");
    wreg(0, 2); wreg(2, 32'hFFF); rreg(2, 0, "R4 clear all");

    // R6 equal-level tie
    wreg(18, 5); wreg(20, 5);
    pins[2] = 0; pins[4] = 0; cyc(4);
    chk("R6 tie lower index", int'(src), 2); chk("R6 tie level", int'(level), 5);
    wreg(2, 4); chk("R6 next in order", int'(src), 4);
    wreg(2, 0); rreg(2, 32'h10, "R4 write zero keeps");

    // R6 internal higher level
    wreg(23, 6); ireq[1] = 1; cyc(1);
    chk("R6 higher level wins", int'(src), 7); chk("R6 higher level", int'(level), 6);
    rreg(2, 32'h90, "R4 internal mirrors req");
    wreg(2, 32'h80); rreg(2, 32'h90, "R4 internal write ignored");

    // R5 level zero never wins
    ireq[2] = 1; cyc(1); chk("R5 zero level loses", int'(src), 7);
    ireq[1] = 0; cyc(1); chk("R5 fallback src", int'(src), 4);
    wreg(2, 32'h10); chk("R5 only zero level pending", int'(valid), 0);

    // wake-up
    ireq[1] = 1; wreg(1, 32'h80);
    sleep_m = 1; cyc(1); chk("R7 sleep internal wakes", int'(wake), 1);
    sleep_m = 0; stop_m = 1; cyc(1); chk("R8 stop internal ignored", int'(wake), 0);
    stop_m = 0; cyc(1); chk("R9 no mode no wake", int'(wake), 0);
    sleep_m = 1; wreg(1, 0); chk("R7 disabled no wake", int'(wake), 0);
    sleep_m = 0;
    wreg(1, 32'h88); pins[3] = 0; stop_m = 1; cyc(4);
    chk("R8 stop external wakes", int'(wake), 1);
    stop_m = 0;

    // R10 pin status
    cyc(3);
    rreg(3, int'(~pins) & 32'h3F, "R10 pin status active low");
    pins = 6'h2A; cyc(3);
    rreg(3, 32'h15, "R10 pin pattern");
    cyc(4);
    finish_run();
  end
endmodule